// File: doc/BRIEF.md
# Status-Flag Branch Condition Evaluator

This block decides whether a conditional branch or a conditional skip goes ahead, and how many cycles that instruction occupies. It reads an 8-bit status register and a 2-bit operation code. It then chooses one of three tests:

- one status bit, picked by a 3-bit index;
- the signed-compare term N XOR V;
- a register bit that the caller has already extracted.

Each test is compared against a polarity bit.

The decision and its cycle cost are registered one clock after a start request is accepted. A small countdown then marks the end of the instruction with a single-cycle done pulse. Instruction fetch, program counter arithmetic and decode sit outside the block. The decoder supplies the operation, the index, the polarity and whether the instruction after a skip is one or two words long.

Top module: `branch_cond_eval`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. With op code 0 (flag branch), the outcome is taken when status bit `cond_sel_i` equals `polarity_i`.
- R2: With op code 1 (signed compare), the outcome is taken when (N XOR V) equals `polarity_i`. Polarity 0 gives greater-or-equal and polarity 1 gives less-than.
- R3: With op code 2 (skip), the skip happens when `test_bit_i` equals `polarity_i`.
- R4: Op code 3 behaves exactly like op code 0.
- R5: A branch (op codes 0, 1 and 3) costs 1 cycle when not taken and 2 cycles when taken. The cost does not depend on `two_word_i`.
- R6: A skip costs 1 cycle when it does not skip. It costs 2 cycles when it skips a one-word instruction (`two_word_i`=0) and 3 cycles when it skips a two-word instruction (`two_word_i`=1).
- R7: `taken_o` and `cycles_o` take their new values in the first cycle after the clock edge that accepts a start. They hold those values until the next accepted start.
- R8: `done_o` is high for exactly one cycle, which is the N-th cycle after the accepting edge, where N is `cycles_o`. `busy_o` is high from the accepting edge until done and is low in the following cycle.
- R9: A start request while `busy_o` is high is ignored. The outputs and the done timing of the instruction in progress are unchanged.
- R10: After reset, `taken_o`, `cycles_o`, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to evaluate one branch or skip |
| op_i | input | 2 | 0 flag branch, 1 signed compare, 2 skip, 3 same as 0 |
| status_i | input | 8 | Status register |
| cond_sel_i | input | 3 | Index of the tested status bit |
| polarity_i | input | 1 | Value the tested term must have for the outcome to be taken |
| test_bit_i | input | 1 | Register bit tested by a skip |
| two_word_i | input | 1 | The instruction after a skip is two words long |
| taken_o | output | 1 | Registered taken/skip decision |
| cycles_o | output | 2 | Registered cycle cost (1 to 3) |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Last cycle of the instruction |

## Verification
The decision and the cost are due in the cycle right after the accepting edge. The bench releases start on the next falling edge and samples `taken_o` and `cycles_o` there, before any later edge can change them. The done pulse is due N cycles after that edge. The bench counts falling edges from the first result cycle until `done_o` is seen, compares that count with the cost it predicted itself, and then checks that `busy_o` has dropped one cycle later. The ignored-start case injects a conflicting request in the second busy cycle. It then confirms that both the count and the held decision follow the first request.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int STATUS_W = 8;
  localparam int CNT_W    = 2;

  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;
  localparam int BIT_T = 6;
  localparam int BIT_I = 7;

  typedef enum logic [1:0] {
    OP_FLAG   = 2'd0,
    OP_SIGNED = 2'd1,
    OP_SKIP   = 2'd2,
    OP_ALIAS  = 2'd3
  } brc_op_e;
endpackage

// File: rtl/brc_cond_sel.sv
module brc_cond_sel
  import brc_pkg::*;
#(
  parameter int STAT_W = STATUS_W,
  localparam int SEL_W = $clog2(STAT_W)
) (
  input  brc_op_e            op,
  input  logic [STAT_W-1:0]  status,
  input  logic [SEL_W-1:0]   sel,
  input  logic               pol,
  input  logic               test_bit,
  output logic               taken
);
  logic raw_term;

  always_comb begin
    unique case (op)
      OP_SIGNED: raw_term = status[BIT_N] ^ status[BIT_V];
      OP_SKIP:   raw_term = test_bit;
      default:   raw_term = status[sel];
    endcase
    taken = (raw_term == pol);
  end
endmodule

// File: rtl/brc_cost.sv
module brc_cost
  import brc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  brc_op_e        op,
  input  logic           taken,
  input  logic           two_word,
  output logic [CW-1:0]  cycles
);
  localparam logic [CW-1:0] COST_FALL  = CW'(1);
  localparam logic [CW-1:0] COST_TAKEN = CW'(2);
  localparam logic [CW-1:0] COST_LONG  = CW'(3);

  always_comb begin
    if (!taken)
      cycles = COST_FALL;
    else if (op == OP_SKIP)
      cycles = two_word ? COST_LONG : COST_TAKEN;
    else
      cycles = COST_TAKEN;
  end
endmodule

// File: rtl/brc_timer.sv
module brc_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] count_q, count_d;
  logic          busy_q, busy_d;

  always_comb begin
    count_d = count_q;
    busy_d  = busy_q;
    if (busy_q) begin
      count_d = count_q - CW'(1);
      busy_d  = (count_q != CW'(1));
    end else if (load) begin
      count_d = load_val;
      busy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      busy_q  <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (count_q == CW'(1));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R8
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count_q != '0));
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import brc_pkg::*;
#(
  parameter int STAT_W = STATUS_W,
  parameter int CW     = CNT_W,
  localparam int SEL_W = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [SEL_W-1:0]  cond_sel_i,
  input  logic              polarity_i,
  input  logic              test_bit_i,
  input  logic              two_word_i,
  output logic              taken_o,
  output logic [CW-1:0]     cycles_o,
  output logic              busy_o,
  output logic              done_o
);
  brc_op_e        op;
  logic           taken_c;
  logic [CW-1:0]  cycles_c;
  logic           accept;
  logic           taken_q, taken_d;
  logic [CW-1:0]  cycles_q, cycles_d;
  logic           busy_w, done_w;

  assign op     = brc_op_e'(op_i);
  assign accept = start_i && !busy_w;

  brc_cond_sel #(.STAT_W(STAT_W)) u_sel (
    .op       (op),
    .status   (status_i),
    .sel      (cond_sel_i),
    .pol      (polarity_i),
    .test_bit (test_bit_i),
    .taken    (taken_c)
  );

  brc_cost #(.CW(CW)) u_cost (
    .op       (op),
    .taken    (taken_c),
    .two_word (two_word_i),
    .cycles   (cycles_c)
  );

  brc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cycles_c),
    .busy     (busy_w),
    .done     (done_w)
  );

  always_comb begin
    taken_d  = taken_q;
    cycles_d = cycles_q;
    if (accept) begin
      taken_d  = taken_c;
      cycles_d = cycles_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      cycles_q <= '0;
    end else begin
      taken_q  <= taken_d;
      cycles_q <= cycles_d;
    end
  end

  assign taken_o  = taken_q;
  assign cycles_o = cycles_q;
  assign busy_o   = busy_w;
  assign done_o   = done_w;

  // R5
  branch_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op != OP_SKIP) |=> (cycles_o == CW'(1)) || (cycles_o == CW'(2)));
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o && (taken_o == $past(taken_c)));
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(taken_o) && $stable(cycles_o));
  // R6
  skip_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_SKIP) && !taken_c |=> cycles_o == CW'(1));
endmodule

// File: tb/branch_cond_eval_test.sv
`timescale 1ns/1ps
module branch_cond_eval_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] op_i;
  logic [7:0] status_i;
  logic [2:0] cond_sel_i;
  logic       polarity_i;
  logic       test_bit_i;
  logic       two_word_i;
  logic       taken_o;
  logic [1:0] cycles_o;
  logic       busy_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  branch_cond_eval uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .status_i(status_i), .cond_sel_i(cond_sel_i), .polarity_i(polarity_i),
    .test_bit_i(test_bit_i), .two_word_i(two_word_i),
    .taken_o(taken_o), .cycles_o(cycles_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [1:0] op, input logic [7:0] st,
                                   input logic [2:0] sel, input logic pol,
                                   input logic tb);
    bit term;
    if (op == 2'd1)      term = st[2] ^ st[3];
    else if (op == 2'd2) term = tb;
    else                 term = st[sel];
    return term == pol;
  endfunction

  function automatic int exp_cost(input logic [1:0] op, input bit tk, input logic tw);
    if (!tk) return 1;
    if (op == 2'd2) return tw ? 3 : 2;
    return 2;
  endfunction

  task automatic run(input logic [1:0] op, input logic [7:0] st, input logic [2:0] sel,
                     input logic pol, input logic tb, input logic tw,
                     input string rq, input bit intrude);
    bit et;
    int ec;
    int k;
    et = exp_taken(op, st, sel, pol, tb);
    ec = exp_cost(op, et, tw);
    op_i = op; status_i = st; cond_sel_i = sel; polarity_i = pol;
    test_bit_i = tb; two_word_i = tw; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({rq, " taken"}, int'(taken_o), int'(et));
    check({rq, " cost"}, int'(cycles_o), ec);
    k = 1;
    while (!done_o && k < 8) begin
      @(negedge clk);
      if (intrude && k == 1) begin
        // R9: conflicting request during busy
        op_i = 2'd2; test_bit_i = ~tb; polarity_i = pol; two_word_i = 1'b0;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      k++;
    end
    start_i = 1'b0;
    check({rq, " R8 done timing"}, k, ec);
    if (intrude) begin
      check("R9 held taken", int'(taken_o), int'(et));
      check("R9 held cost", int'(cycles_o), ec);
    end
    @(negedge clk);
    check({rq, " R8 busy falls"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; status_i = '0; cond_sel_i = '0;
    polarity_i = 1'b0; test_bit_i = 1'b0; two_word_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 taken", int'(taken_o), 0);
    check("R10 cycles", int'(cycles_o), 0);
    check("R10 busy", int'(busy_o), 0);
    check("R10 done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R5: every status value, index and polarity
    for (int s = 0; s < 256; s++)
      for (int i = 0; i < 8; i++)
        for (int p = 0; p < 2; p++)
          run(2'd0, 8'(s), 3'(i), 1'(p), 1'b0, 1'(s & 1), "R1 R5", 1'b0);

    // R2: signed compare over every status value
    for (int s = 0; s < 256; s++)
      for (int p = 0; p < 2; p++)
        run(2'd1, 8'(s), 3'(s), 1'(p), 1'b0, 1'b0, "R2 R5", 1'b0);

    // R3 / R6: skip over every bit, polarity and length
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          run(2'd2, 8'h5A, 3'd1, 1'(p), 1'(b), 1'(w), "R3 R6", 1'b0);

    // R4: alias op code
    for (int s = 0; s < 256; s += 7)
      for (int i = 0; i < 8; i++)
        run(2'd3, 8'(s), 3'(i), 1'b1, 1'b0, 1'b1, "R4", 1'b0);

    // R7 / R9: long skip with a conflicting request while busy
    run(2'd2, 8'h00, 3'd0, 1'b1, 1'b1, 1'b1, "R7 R9", 1'b1);
    run(2'd0, 8'h02, 3'd1, 1'b1, 1'b0, 1'b0, "R7 R9", 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule